// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Threshold Unit

This block sits beside the storage of a deep synchronous FIFO and turns the FIFO's current word count into three active-low status flags: almost-empty, almost-full and half-full. Two thresholds are held inside it. The empty threshold `n` sets how close to empty the almost-empty flag warns. The full threshold `m` sets how close to full the almost-full flag warns. The FIFO storage and its pointers are outside this block. The word count comes in as an input.

Software or a neighbouring controller programs the thresholds on the write clock. There are two ways to do this. One way shifts them in a bit at a time on a serial line. The other writes a whole value per edge from the write data bus. Which way is active, and which pair of power-up thresholds applies, is fixed by a strap. The strap is the write-side offset-select pin, sampled while master reset is held. On the read clock, the thresholds can be read back onto the data output bus in either mode.

A partial reset rewinds the access sequencing but keeps the thresholds and the programming mode. A master reset reloads the strap-selected defaults.

Top module: `afl_offset_unit`

## Requirements
- R1: While `master_rst` is high, `wr_ofs` acts as a strap. Low selects parallel programming with both thresholds set to 127. High selects serial programming with both thresholds set to 1023.
- R2: After master reset, `rd_data` is all zeros. With `word_cnt` = 0, `ae_n` = 0, `af_n` = 1 and `hf_n` = 1.
- R3: In parallel mode, a `wclk` edge with `wr_en` = 1 and `wr_ofs` = 1 stores `wr_data[OW-1:0]` into one threshold. Successive loads alternate, starting with the empty threshold `n` and then the full threshold `m`.
- R4: In serial mode, a `wclk` edge with `ser_en` = 1 and `wr_ofs` = 1 stores `ser_in` as the next threshold bit. Bits go least significant first: bits 0..OW-1 of `n`, then bits 0..OW-1 of `m`. After that the sequence wraps back to bit 0 of `n`.
- R5: In parallel mode, serial shifts leave both thresholds unchanged. In serial mode, parallel loads leave both thresholds unchanged.
- R6: A `rclk` edge with `rd_en` = 1 and `rd_ofs` = 1 places a threshold, zero-extended, on `rd_data`. Successive read-backs alternate between `n` and `m`, starting with `n`. Otherwise `rd_data` holds its value.
- R7: One `wclk` edge after `word_cnt` is presented, `ae_n` is 0 exactly when `word_cnt` < `n`.
- R8: One `wclk` edge after `word_cnt` is presented, `af_n` is 0 exactly when `word_cnt` > DEPTH − `m`.
- R9: One `wclk` edge after `word_cnt` is presented, `hf_n` is 0 exactly when `word_cnt` > DEPTH/2.
- R10: `part_rst` keeps both thresholds and the programming mode. It returns the parallel-load alternation, the read-back alternation and the serial bit position to their starting points, and it clears `rd_data`.
- R11: A master reset after programming restores the strap-selected default thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| master_rst | input | 1 | Synchronous master reset, active high, sampled on both clocks |
| part_rst | input | 1 | Synchronous partial reset, active high, sampled on both clocks |
| wr_ofs | input | 1 | Write-side threshold access select; mode strap during master reset |
| wr_en | input | 1 | Parallel load enable (with `wr_ofs`) |
| ser_en | input | 1 | Serial shift enable (with `wr_ofs`) |
| ser_in | input | 1 | Serial threshold bit |
| wr_data | input | DW | Write data bus; low OW bits carry a parallel threshold |
| rd_ofs | input | 1 | Read-side threshold access select |
| rd_en | input | 1 | Read-back enable (with `rd_ofs`) |
| word_cnt | input | CW | Current FIFO word count, 0..DEPTH |
| rd_data | output | DW | Read-back data bus |
| ae_n | output | 1 | Almost-empty flag, low when active |
| af_n | output | 1 | Almost-full flag, low when active |
| hf_n | output | 1 | Half-full flag, low when active |

## Verification
The bench probes each flag exactly at its threshold and one count away, so an off-by-one comparison (≤ instead of <) flips a flag at the wrong count. It programs distinct values into `n` and `m` and reads them back in sequence. A swapped or non-alternating pointer would then return the wrong threshold, and a pointer that partial reset fails to rewind would load or return the full threshold where the empty one is expected. It abandons a serial shift partway, applies a partial reset, and then shifts a full pair. A bit position that partial reset did not clear would leave both thresholds misaligned. Loads through the inactive method are followed by read-back, which exposes a mode gate that leaks.

// File: rtl/afl_pkg.sv
package afl_pkg;
   // Which threshold an access sequence currently targets
   typedef enum logic {
      SEL_EMPTY = 1'b0,
      SEL_FULL  = 1'b1
   } ofs_sel_e;

   // Strap-selected defaults
   localparam int unsigned DEF_PAR = 127;
   localparam int unsigned DEF_SER = 1023;
endpackage

// File: rtl/afl_ofs_regs.sv
module afl_ofs_regs
   import afl_pkg::*;
#(
   parameter int unsigned DW = 18,
   parameter int unsigned OW = 14
) (
   input  logic                clk,
   input  logic                master_rst,
   input  logic                part_rst,
   input  logic                wr_ofs,
   input  logic                wr_en,
   input  logic                ser_en,
   input  logic                ser_in,
   input  logic [DW-1:0]       wr_data,
   output logic                ser_mode,
   output logic [1:0][OW-1:0]  ofs
);
   localparam int unsigned NBITS = 2 * OW;
   localparam int unsigned SBW   = $clog2(NBITS);
   localparam int unsigned OBW   = $clog2(OW);

   ofs_sel_e          par_sel_q;
   logic [SBW-1:0]    sbit_q;
   logic              ser_hi;
   logic [SBW-1:0]    sbit_rel;
   logic              ser_go;
   logic              par_go;

   assign ser_go   = ser_mode && ser_en && wr_ofs;
   assign par_go   = !ser_mode && wr_en && wr_ofs;
   assign ser_hi   = (sbit_q >= SBW'(OW));
   assign sbit_rel = ser_hi ? (sbit_q - SBW'(OW)) : sbit_q;

   always_ff @(posedge clk) begin
      if (master_rst) ser_mode <= wr_ofs;
   end

   always_ff @(posedge clk) begin
      if (master_rst || part_rst) begin
         par_sel_q <= SEL_EMPTY;
         sbit_q    <= '0;
      end else begin
         if (par_go) par_sel_q <= ofs_sel_e'(~par_sel_q);
         if (ser_go) sbit_q <= (sbit_q == SBW'(NBITS - 1)) ? '0 : sbit_q + 1'b1;
      end
   end

   for (genvar g = 0; g < 2; g++) begin : g_ofs
      logic [OW-1:0] val_q;
      always_ff @(posedge clk) begin
         if (master_rst) begin
            val_q <= wr_ofs ? OW'(DEF_SER) : OW'(DEF_PAR);
         end else if (!part_rst) begin
            if (par_go && (par_sel_q == ofs_sel_e'(g)))
               val_q <= wr_data[OW-1:0];
            else if (ser_go && (ser_hi == 1'(g)))
               val_q[sbit_rel[OBW-1:0]] <= ser_in;
         end
      end
      assign ofs[g] = val_q;
   end

   // R10: partial reset keeps both thresholds
   a_r10_keep_ofs: assert property (@(posedge clk) disable iff (master_rst)
      part_rst |=> ($stable(ofs[0]) && $stable(ofs[1])));
   // R5: parallel loads do nothing in serial mode
   a_r5_ser_gate: assert property (@(posedge clk) disable iff (master_rst || part_rst)
      (ser_mode && wr_en && wr_ofs && !ser_en) |=> ($stable(ofs[0]) && $stable(ofs[1])));
   // R5: serial shifts do nothing in parallel mode
   a_r5_par_gate: assert property (@(posedge clk) disable iff (master_rst || part_rst)
      (!ser_mode && ser_en && wr_ofs && !wr_en) |=> ($stable(ofs[0]) && $stable(ofs[1])));
endmodule

// File: rtl/afl_readback.sv
module afl_readback
   import afl_pkg::*;
#(
   parameter int unsigned DW = 18,
   parameter int unsigned OW = 14
) (
   input  logic                clk,
   input  logic                master_rst,
   input  logic                part_rst,
   input  logic                rd_en,
   input  logic                rd_ofs,
   input  logic [1:0][OW-1:0]  ofs,
   output logic [DW-1:0]       rd_data
);
   ofs_sel_e rd_sel_q;

   always_ff @(posedge clk) begin
      if (master_rst || part_rst) begin
         rd_sel_q <= SEL_EMPTY;
         rd_data  <= '0;
      end else if (rd_en && rd_ofs) begin
         rd_data  <= DW'(ofs[rd_sel_q]);
         rd_sel_q <= ofs_sel_e'(~rd_sel_q);
      end
   end

   // R6: bus holds when no read-back is requested
   a_r6_hold: assert property (@(posedge clk) disable iff (master_rst || part_rst)
      !(rd_en && rd_ofs) |=> $stable(rd_data));
   // R10: partial reset clears the bus
   a_r10_clear: assert property (@(posedge clk) disable iff (master_rst)
      part_rst |=> (rd_data == '0));
endmodule

// File: rtl/afl_flags.sv
module afl_flags #(
   parameter int unsigned DEPTH = 16384,
   parameter int unsigned OW    = 14,
   parameter int unsigned CW    = 15
) (
   input  logic               clk,
   input  logic               master_rst,
   input  logic               part_rst,
   input  logic [CW-1:0]      word_cnt,
   input  logic [1:0][OW-1:0] ofs,
   output logic               ae_n,
   output logic               af_n,
   output logic               hf_n
);
   localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

   logic [CW-1:0] full_lim;
   assign full_lim = CW'(DEPTH) - CW'(ofs[1]);

   always_ff @(posedge clk) begin
      if (master_rst || part_rst) begin
         ae_n <= 1'b0;
         af_n <= 1'b1;
         hf_n <= 1'b1;
      end else begin
         ae_n <= !(word_cnt < CW'(ofs[0]));
         af_n <= !(word_cnt > full_lim);
         hf_n <= !(word_cnt > HALF);
      end
   end

   a_r7_ae_fall: assert property (@(posedge clk) disable iff (master_rst || part_rst)
      $fell(ae_n) |-> ($past(word_cnt) < CW'($past(ofs[0]))));
   a_r8_af_fall: assert property (@(posedge clk) disable iff (master_rst || part_rst)
      $fell(af_n) |-> ($past(word_cnt) > (CW'(DEPTH) - CW'($past(ofs[1])))));
   a_r9_hf_fall: assert property (@(posedge clk) disable iff (master_rst || part_rst)
      $fell(hf_n) |-> ($past(word_cnt) > HALF));
endmodule

// File: rtl/afl_offset_unit.sv
module afl_offset_unit #(
   parameter int unsigned DEPTH = 16384,
   parameter int unsigned DW    = 18,
   parameter int unsigned OW    = $clog2(DEPTH),
   parameter int unsigned CW    = OW + 1
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          master_rst,
   input  logic          part_rst,
   input  logic          wr_ofs,
   input  logic          wr_en,
   input  logic          ser_en,
   input  logic          ser_in,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_ofs,
   input  logic          rd_en,
   input  logic [CW-1:0] word_cnt,
   output logic [DW-1:0] rd_data,
   output logic          ae_n,
   output logic          af_n,
   output logic          hf_n
);
   if ((1 << OW) != DEPTH) begin : g_chk_depth
      $error("DEPTH must be a power of two");
   end
   if (DW < OW) begin : g_chk_width
      $error("data bus narrower than a threshold");
   end
   if (afl_pkg::DEF_SER >= DEPTH) begin : g_chk_def
      $error("default threshold exceeds DEPTH");
   end

   logic [1:0][OW-1:0] ofs;
   logic               ser_mode;

   afl_ofs_regs #(.DW(DW), .OW(OW)) u_regs (
      .clk(wclk), .master_rst(master_rst), .part_rst(part_rst),
      .wr_ofs(wr_ofs), .wr_en(wr_en), .ser_en(ser_en), .ser_in(ser_in),
      .wr_data(wr_data), .ser_mode(ser_mode), .ofs(ofs)
   );

   afl_readback #(.DW(DW), .OW(OW)) u_rb (
      .clk(rclk), .master_rst(master_rst), .part_rst(part_rst),
      .rd_en(rd_en), .rd_ofs(rd_ofs), .ofs(ofs), .rd_data(rd_data)
   );

   afl_flags #(.DEPTH(DEPTH), .OW(OW), .CW(CW)) u_flags (
      .clk(wclk), .master_rst(master_rst), .part_rst(part_rst),
      .word_cnt(word_cnt), .ofs(ofs), .ae_n(ae_n), .af_n(af_n), .hf_n(hf_n)
   );

   // R1: strap picks the defaults seen right after master reset
   a_r1_defaults: assert property (@(posedge wclk)
      master_rst |=> (ofs[0] == (ser_mode ? OW'(afl_pkg::DEF_SER) : OW'(afl_pkg::DEF_PAR))));
endmodule

// File: tb/afl_offset_unit_tb.sv
module afl_offset_unit_tb;
   localparam int DEPTH = 16384;
   localparam int DW    = 18;
   localparam int OW    = 14;
   localparam int CW    = 15;

   logic wclk = 0, rclk = 0;
   logic master_rst = 1, part_rst = 0;
   logic wr_ofs = 0, wr_en = 0, ser_en = 0, ser_in = 0;
   logic [DW-1:0] wr_data = '0;
   logic rd_ofs = 0, rd_en = 0;
   logic [CW-1:0] word_cnt = '0;
   logic [DW-1:0] rd_data;
   logic ae_n, af_n, hf_n;

   always #2.5 wclk = ~wclk;
   always #3.5 rclk = ~rclk;

   afl_offset_unit #(.DEPTH(DEPTH), .DW(DW)) u_dut (
      .wclk(wclk), .rclk(rclk), .master_rst(master_rst), .part_rst(part_rst),
      .wr_ofs(wr_ofs), .wr_en(wr_en), .ser_en(ser_en), .ser_in(ser_in),
      .wr_data(wr_data), .rd_ofs(rd_ofs), .rd_en(rd_en), .word_cnt(word_cnt),
      .rd_data(rd_data), .ae_n(ae_n), .af_n(af_n), .hf_n(hf_n)
   );

   int n_run = 0, n_fail = 0;
   int mn, mm, wsel, rsel, sb;
   bit mser;
   int    exp_v[$];
   string exp_t[$];
   logic  issued = 0;

   task automatic check(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // monitor: compare each read-back with the scoreboard head
   always @(posedge rclk) issued <= rd_en && rd_ofs && !master_rst && !part_rst;
   always @(negedge rclk) begin
      if (issued) begin
         if (exp_v.size() == 0) begin
            n_run++; n_fail++;
            $display("FAIL R6: actual %0d expected none", rd_data);
         end else begin
            check(exp_t.pop_front(), int'(rd_data), exp_v.pop_front());
         end
      end
   end

   task automatic do_mrst(bit strap);
      @(negedge wclk); master_rst = 1; wr_ofs = strap;
      repeat (6) @(negedge rclk);
      @(negedge wclk); master_rst = 0; wr_ofs = 0;
      mser = strap; mn = strap ? 1023 : 127; mm = mn;
      wsel = 0; rsel = 0; sb = 0;
   endtask

   task automatic do_prst();
      @(negedge wclk); part_rst = 1;
      repeat (6) @(negedge rclk);
      @(negedge wclk); part_rst = 0;
      wsel = 0; rsel = 0; sb = 0;
   endtask

   task automatic rb(string tag);
      @(negedge rclk); rd_en = 1; rd_ofs = 1;
      exp_v.push_back(rsel ? mm : mn); exp_t.push_back(tag);
      rsel ^= 1;
      @(negedge rclk); rd_en = 0; rd_ofs = 0;
      @(negedge rclk);
   endtask

   task automatic pload(int v);
      @(negedge wclk); wr_en = 1; wr_ofs = 1; wr_data = DW'(v);
      @(negedge wclk); wr_en = 0; wr_ofs = 0;
      if (!mser) begin
         if (wsel) mm = v; else mn = v;
         wsel ^= 1;
      end
   endtask

   task automatic sbit(bit b);
      @(negedge wclk); ser_en = 1; wr_ofs = 1; ser_in = b;
      @(negedge wclk); ser_en = 0; wr_ofs = 0;
      if (mser) begin
         if (sb < OW) mn[sb] = b; else mm[sb - OW] = b;
         sb = (sb == 2 * OW - 1) ? 0 : sb + 1;
      end
   endtask

   task automatic sload(int n, int m);
      for (int i = 0; i < OW; i++) sbit(n[i]);
      for (int i = 0; i < OW; i++) sbit(m[i]);
   endtask

   task automatic flags(int c, string tag);
      @(negedge wclk); word_cnt = CW'(c);
      @(negedge wclk);
      check({tag, " R7 ae_n"}, ae_n, !(c < mn));
      check({tag, " R8 af_n"}, af_n, !(c > DEPTH - mm));
      check({tag, " R9 hf_n"}, hf_n, !(c > DEPTH / 2));
   endtask

   initial begin
      do_mrst(0);
      // R2: reset state
      @(negedge wclk);
      check("R2 rd_data", int'(rd_data), 0);
      check("R2 ae_n", ae_n, 0);
      check("R2 af_n", af_n, 1);
      check("R2 hf_n", hf_n, 1);
      // R1: parallel defaults
      rb("R1 n=127"); rb("R1 m=127");
      // R3: alternating parallel loads
      pload(40); pload(100);
      rb("R3 n"); rb("R3 m");
      // R6: bus holds when idle
      repeat (4) @(negedge rclk);
      check("R6 hold", int'(rd_data), 100);
      // R7/R8/R9: thresholds and neighbours
      flags(39, "n-1"); flags(40, "n");
      flags(DEPTH - 100, "lim"); flags(DEPTH - 99, "lim+1");
      flags(DEPTH / 2, "half"); flags(DEPTH / 2 + 1, "half+1");
      flags(DEPTH, "full"); flags(0, "zero");
      // R5: serial shifts ignored in parallel mode
      for (int i = 0; i < 5; i++) sbit(1'b1);
      rb("R5 par n"); rb("R5 par m");
      // R10: partial reset rewinds pointers, keeps values and mode
      pload(55);
      rb("R10 pre n");
      do_prst();
      @(negedge rclk);
      check("R10 rd_data cleared", int'(rd_data), 0);
      pload(66);
      rb("R10 n after"); rb("R10 m kept");
      for (int i = 0; i < 3; i++) sbit(1'b1);
      rb("R10 mode kept n");
      // R1: serial defaults
      do_mrst(1);
      rb("R1 n=1023"); rb("R1 m=1023");
      // R5: parallel loads ignored in serial mode
      pload(7); pload(8);
      rb("R5 ser n"); rb("R5 ser m");
      // R4: serial programming
      sload(5, 9);
      rb("R4 n"); rb("R4 m");
      flags(4, "ser n-1"); flags(5, "ser n");
      flags(DEPTH - 9, "ser lim"); flags(DEPTH - 8, "ser lim+1");
      // R10: abandoned shift then partial reset
      for (int i = 0; i < 3; i++) sbit(1'b1);
      do_prst();
      sload(12, 20);
      rb("R10 ser n"); rb("R10 ser m");
      // R4: sequence wraps back to n
      sload(300, 600);
      rb("R4 wrap n"); rb("R4 wrap m");
      // R11: master reset restores defaults
      do_mrst(0);
      rb("R11 n"); rb("R11 m");
      flags(126, "def n-1"); flags(127, "def n");
      repeat (4) @(negedge rclk);
      check("R6 scoreboard drained", exp_v.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #500000;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule